// File: doc/BRIEF.md
# Merging Write Buffer with Read Bypass

This block sits between a write-through first-level cache and main memory. The cache hands it word writes, or a whole replaced dirty block, and the buffer writes them to memory in the background. A write that lands in a block that already has a pending entry is folded into that entry, so the cache stalls only when a new entry is needed and all entries are taken. Writes marked as memory-mapped I/O are never folded, so each I/O event reaches memory as its own transaction.

A read miss can go to memory ahead of pending writes. Before it does, the read address is compared against every pending entry. If nothing matches, the read is cleared to proceed. While a read is presented, the buffer holds off starting a new drain, so the read gets the memory first. If the newest matching entry holds the requested word, that word is forwarded from the buffer. If the entry does not hold the word, the read must wait until the entry has drained.

The memory side drains entries oldest first. Each transaction carries one entry: the block address, the word data, a per-word write mask taken from the word valid bits, and the I/O flag. The transaction uses a request/acknowledge handshake.

Top module: `wbuf_merge`

## Requirements
- R1: After reset the buffer is empty: `mem_req` is 0, `wr_ready` is 1, and a presented read sees `rd_clear` = 1.
- R2: A non-I/O write to a block that has a pending non-I/O entry, which is not currently being drained, is accepted even when the buffer is full. It updates the masked words of that entry in place and takes no new entry.
- R3: An I/O write (`wr_io` = 1) never merges and never takes merges. It always needs a new entry and drains as its own transaction with `mem_io` = 1.
- R4: `wr_ready` is 0 exactly when the presented write needs a new entry and all ENTRIES entries are occupied.
- R5: Entries drain to memory in the order in which they were allocated.
- R6: `mem_req` rises one cycle after a drain starts. `mem_blk`, `mem_data`, `mem_wmask` and `mem_io` hold steady until the cycle in which `mem_ack` is high. `mem_req` is 0 in the cycle after the ack. Bit w of `mem_wmask` is 1 only if word w of the entry was written.
- R7: With `rd_valid` high, `rd_clear` is 1 if and only if no pending entry has block address `rd_blk`.
- R8: With `rd_valid` high, if the newest pending entry for `rd_blk` holds word `rd_word`, then `rd_fwd` is 1 and `rd_fwd_data` gives that word's latest written value. Word w sits in bits [w*DATA_W +: DATA_W] of the block data buses.
- R9: If the newest pending entry for `rd_blk` lacks word `rd_word`, then both `rd_fwd` and `rd_clear` are 0 until that entry has drained.
- R10: While `rd_valid` is high, no new drain starts. If `mem_req` is 0, it stays 0 in the next cycle.
- R11: A non-I/O write to the block of the entry currently being drained does not merge into it. It takes a new entry instead.
- R12: A write whose `wr_mask` is all ones (a replaced dirty block) takes a single entry and drains with an all-ones `mem_wmask`. `wr_mask` is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write presented |
| wr_blk | input | BADDR_W | Block address of the write |
| wr_mask | input | WORDS | Words of the block being written |
| wr_data | input | WORDS*DATA_W | Word data, word w in slice w |
| wr_io | input | 1 | Write is memory-mapped I/O |
| wr_ready | output | 1 | Write accepted this cycle |
| rd_valid | input | 1 | Read miss presented for checking |
| rd_blk | input | BADDR_W | Block address of the read |
| rd_word | input | WIDX | Word index of the read |
| rd_fwd | output | 1 | Requested word forwarded from the buffer |
| rd_fwd_data | output | DATA_W | Forwarded word |
| rd_clear | output | 1 | No conflict; read may go to memory |
| mem_req | output | 1 | Drain transaction pending |
| mem_blk | output | BADDR_W | Block address of the drained entry |
| mem_data | output | WORDS*DATA_W | Data of the drained entry |
| mem_wmask | output | WORDS | Per-word write mask |
| mem_io | output | 1 | Drained entry is I/O |
| mem_ack | input | 1 | Memory accepts the transaction |

## Verification
A wrong slot pointer or occupancy count shows up in the same cycle on `wr_ready`, `rd_clear` and `rd_fwd`, because those outputs are derived combinationally from the stored entries. A lost or misplaced merge stays hidden until the affected entry reaches the head. It then shows on `mem_data` or `mem_wmask`, or earlier, if a read of that word is forwarded. The bench keeps its own ordered model of the entries and compares every port in every cycle. Each divergence is therefore reported no later than the drain of the entry it corrupted.

// File: rtl/wbuf_merge.sv
module wbuf_merge #(
  parameter int ENTRIES = 4,
  parameter int WORDS   = 4,
  parameter int DATA_W  = 16,
  parameter int BADDR_W = 12,
  localparam int WIDX   = $clog2(WORDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  input  logic [BADDR_W-1:0]        wr_blk,
  input  logic [WORDS-1:0]          wr_mask,
  input  logic [WORDS*DATA_W-1:0]   wr_data,
  input  logic                      wr_io,
  output logic                      wr_ready,
  input  logic                      rd_valid,
  input  logic [BADDR_W-1:0]        rd_blk,
  input  logic [WIDX-1:0]           rd_word,
  output logic                      rd_fwd,
  output logic [DATA_W-1:0]         rd_fwd_data,
  output logic                      rd_clear,
  output logic                      mem_req,
  output logic [BADDR_W-1:0]        mem_blk,
  output logic [WORDS*DATA_W-1:0]   mem_data,
  output logic [WORDS-1:0]          mem_wmask,
  output logic                      mem_io,
  input  logic                      mem_ack
);
  localparam int PW = $clog2(ENTRIES);
  localparam int CW = $clog2(ENTRIES + 1);

  logic [BADDR_W-1:0]      e_blk  [ENTRIES];
  logic [WORDS-1:0]        e_vld  [ENTRIES];
  logic [WORDS*DATA_W-1:0] e_data [ENTRIES];
  logic                    e_io   [ENTRIES];

  logic [PW-1:0] head, tail, midx, ridx, wsel;
  logic [CW-1:0] count;
  logic          busy, mhit, rhit, full, wr_fire, alloc, pop, start;
  logic [ENTRIES-1:0] live;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      live[i] = CW'(PW'(PW'(i) - head)) < count;
  end

  always_comb begin
    mhit = 1'b0;
    midx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (live[i] && !e_io[i] && !wr_io && e_blk[i] == wr_blk &&
          !(busy && PW'(i) == head)) begin
        mhit = 1'b1;
        midx = PW'(i);
      end
  end

  always_comb begin
    rhit = 1'b0;
    ridx = head;
    for (int j = 0; j < ENTRIES; j++)
      if (CW'(j) < count && e_blk[PW'(head + PW'(j))] == rd_blk) begin
        rhit = 1'b1;
        ridx = PW'(head + PW'(j));
      end
  end

  assign full     = count == CW'(ENTRIES);
  assign tail     = PW'(head + PW'(count));
  assign wr_ready = mhit || !full;
  assign wr_fire  = wr_valid && wr_ready;
  assign alloc    = wr_fire && !mhit;
  assign wsel     = mhit ? midx : tail;
  assign pop      = busy && mem_ack;
  assign start    = !busy && count != '0 && !rd_valid;

  assign rd_clear    = rd_valid && !rhit;
  assign rd_fwd      = rd_valid && rhit && e_vld[ridx][rd_word];
  assign rd_fwd_data = e_data[ridx][rd_word*DATA_W +: DATA_W];

  assign mem_req   = busy;
  assign mem_blk   = e_blk[head];
  assign mem_data  = e_data[head];
  assign mem_wmask = e_vld[head];
  assign mem_io    = e_io[head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
      busy  <= 1'b0;
    end else begin
      head  <= head + PW'(pop);
      count <= count + CW'(alloc) - CW'(pop);
      busy  <= busy ? !mem_ack : start;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      if (!mhit) begin
        e_blk[wsel] <= wr_blk;
        e_io[wsel]  <= wr_io;
      end
      e_vld[wsel] <= (mhit ? e_vld[wsel] : '0) | wr_mask;
      for (int w = 0; w < WORDS; w++)
        if (wr_mask[w])
          e_data[wsel][w*DATA_W +: DATA_W] <= wr_data[w*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/wbuf_merge_chk.sv
module wbuf_merge_chk #(
  parameter int WORDS   = 4,
  parameter int DATA_W  = 16,
  parameter int BADDR_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rd_valid,
  input logic                    rd_fwd,
  input logic                    rd_clear,
  input logic                    mem_req,
  input logic                    mem_ack,
  input logic [BADDR_W-1:0]      mem_blk,
  input logic [WORDS*DATA_W-1:0] mem_data,
  input logic [WORDS-1:0]        mem_wmask,
  input logic                    mem_io
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_blk) && $stable(mem_data) &&
                            $stable(mem_wmask) && $stable(mem_io));

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);

  p_mask_nonzero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_wmask != '0);

  p_read_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req && rd_valid |=> !mem_req);

  p_fwd_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_fwd && rd_clear));

  p_idle_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !rd_fwd && !rd_clear);
endmodule

bind wbuf_merge wbuf_merge_chk #(.WORDS(WORDS), .DATA_W(DATA_W), .BADDR_W(BADDR_W)) u_chk (.*);

// File: tb/tb_wbuf_merge.sv
`timescale 1ns/1ps
module tb_wbuf_merge;
  localparam int E = 4, W = 4, D = 16, B = 12;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_io = 0, rd_valid = 0, mem_ack = 0;
  logic [B-1:0] wr_blk = 0, rd_blk = 0;
  logic [W-1:0] wr_mask = 0;
  logic [W*D-1:0] wr_data = 0;
  logic [1:0] rd_word = 0;
  logic wr_ready, rd_fwd, rd_clear, mem_req, mem_io;
  logic [D-1:0] rd_fwd_data;
  logic [B-1:0] mem_blk;
  logic [W*D-1:0] mem_data;
  logic [W-1:0] mem_wmask;

  wbuf_merge #(.ENTRIES(E), .WORDS(W), .DATA_W(D), .BADDR_W(B)) dut (.*);

  always #5 clk = ~clk;

  int vecs = 0, fails = 0;
  bit done = 0;

  logic [B-1:0]   m_blk  [E];
  logic [W-1:0]   m_vld  [E];
  logic [W*D-1:0] m_data [E];
  logic           m_io   [E];
  int  m_cnt = 0;
  bit  m_busy = 0;

  task automatic chk(bit ok, string tag, logic [63:0] got, logic [63:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [W*D-1:0] wexp(logic [W-1:0] m);
    logic [W*D-1:0] r = '0;
    for (int w = 0; w < W; w++) if (m[w]) r[w*D +: D] = '1;
    return r;
  endfunction

  task automatic step(bit wv, logic [B-1:0] wb, logic [W-1:0] wm, logic [W*D-1:0] wd,
                      bit wio, bit rv, logic [B-1:0] rb, logic [1:0] rw, bit ack);
    int mi, ri, pre_cnt;
    bit exp_ready, exp_fwd, head_match;
    string tag;
    @(negedge clk);
    wr_valid = wv; wr_blk = wb; wr_mask = wm; wr_data = wd; wr_io = wio;
    rd_valid = rv; rd_blk = rb; rd_word = rw; mem_ack = ack;
    #1;
    mi = -1;
    head_match = 0;
    for (int k = 0; k < m_cnt; k++)
      if (!wio && !m_io[k] && m_blk[k] == wb) begin
        if (m_busy && k == 0) head_match = 1;
        else mi = k;
      end
    exp_ready = (mi >= 0) || m_cnt < E;
    if (wv) begin
      tag = (mi >= 0) ? "R2" : (m_cnt == E) ? "R4" : head_match ? "R11" : wio ? "R3" : "R12";
      chk(wr_ready == exp_ready, tag, 64'(wr_ready), 64'(exp_ready));
    end
    ri = -1;
    for (int k = 0; k < m_cnt; k++) if (m_blk[k] == rb) ri = k;
    if (rv) begin
      exp_fwd = ri >= 0 && m_vld[ri][rw];
      chk(rd_clear == (ri < 0), "R7", 64'(rd_clear), 64'(ri < 0));
      chk(rd_fwd == exp_fwd, exp_fwd ? "R8" : "R9", 64'(rd_fwd), 64'(exp_fwd));
      if (exp_fwd) chk(rd_fwd_data == m_data[ri][rw*D +: D], "R8",
                       64'(rd_fwd_data), 64'(m_data[ri][rw*D +: D]));
    end
    chk(mem_req == m_busy, "R10", 64'(mem_req), 64'(m_busy));
    if (m_busy && mem_req) begin
      chk(mem_blk == m_blk[0], "R5", 64'(mem_blk), 64'(m_blk[0]));
      chk(mem_wmask == m_vld[0], "R6", 64'(mem_wmask), 64'(m_vld[0]));
      chk(mem_io == m_io[0], "R3", 64'(mem_io), 64'(m_io[0]));
      chk((mem_data & wexp(m_vld[0])) == (m_data[0] & wexp(m_vld[0])), "R6",
          mem_data & wexp(m_vld[0]), m_data[0] & wexp(m_vld[0]));
    end
    pre_cnt = m_cnt;
    if (wv && exp_ready) begin
      if (mi < 0) begin
        mi = m_cnt; m_cnt++;
        m_blk[mi] = wb; m_io[mi] = wio; m_vld[mi] = '0; m_data[mi] = '0;
      end
      m_vld[mi] |= wm;
      for (int w = 0; w < W; w++) if (wm[w]) m_data[mi][w*D +: D] = wd[w*D +: D];
    end
    if (m_busy && ack) begin
      for (int k = 0; k < E - 1; k++) begin
        m_blk[k] = m_blk[k+1]; m_vld[k] = m_vld[k+1];
        m_data[k] = m_data[k+1]; m_io[k] = m_io[k+1];
      end
      m_cnt--;
    end
    m_busy = m_busy ? !ack : (pre_cnt > 0 && !rv);
  endtask

  task automatic wr(logic [B-1:0] b, logic [W-1:0] m, bit io, bit rv, bit ack);
    step(1, b, m, {$urandom, $urandom}, io, rv, b, 2'd0, ack);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: empty after reset
    step(0, 0, 0, 0, 0, 1, 12'h7, 2'd0, 0);
    chk(wr_ready == 1'b1, "R1", 64'(wr_ready), 64'd1);
    chk(mem_req == 1'b0, "R1", 64'(mem_req), 64'd0);
    chk(rd_clear == 1'b1, "R1", 64'(rd_clear), 64'd1);
    // fill with reads held, drain blocked (R10)
    wr(12'h1, 4'b0001, 0, 1, 0);
    wr(12'h2, 4'b0010, 0, 1, 0);
    wr(12'h3, 4'b1111, 0, 1, 0);   // R12 full block
    wr(12'h4, 4'b0001, 1, 1, 0);   // R3 I/O entry
    wr(12'h2, 4'b1000, 0, 1, 0);   // R2 merge while full
    wr(12'h5, 4'b0001, 0, 1, 0);   // R4 stall
    wr(12'h4, 4'b0010, 1, 1, 0);   // R3 no merge, stall
    step(0, 0, 0, 0, 0, 1, 12'h2, 2'd3, 0); // R8 forward
    step(0, 0, 0, 0, 0, 1, 12'h2, 2'd0, 0); // R9 wait
    step(0, 0, 0, 0, 0, 1, 12'h9, 2'd0, 0); // R7 clear
    // start drain, then write into the draining block (R11)
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    wr(12'h2, 4'b0100, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 12'h2, 2'd2, 0);
    repeat (12) step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit wv = $urandom_range(0, 99) < 55;
      bit io = $urandom_range(0, 99) < 15;
      logic [W-1:0] m = ($urandom_range(0, 9) == 0) ? 4'hF : (4'b1 << $urandom_range(0, 3));
      if ($urandom_range(0, 4) == 0) m |= 4'b1 << $urandom_range(0, 3);
      step(wv, 12'($urandom_range(0, 5)), m, {$urandom, $urandom}, io,
           $urandom_range(0, 99) < 30, 12'($urandom_range(0, 6)), 2'($urandom_range(0, 3)),
           $urandom_range(0, 99) < 40);
    end
    repeat (20) step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk(mem_req == 1'b0 && m_cnt == 0, "R5", 64'(mem_req), 64'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule